// File: doc/BRIEF.md
# Dibit Differential Phase Encoder

This block sits in front of a four-phase modulator on the transmit side. Whole bytes come in through a valid/ready write port. They pass through a two-stage buffer made of a holding register and a symbol shift register. While one byte is being sent, the writer can already park the next one. Each byte is cut into four two-bit symbols, and the least significant symbol goes out first. Each symbol becomes a differential phase step, and the step is added modulo four to a running absolute phase index.

The modulator supplies a one-cycle symbol strobe. On each strobe the block consumes one symbol. Its phase output then changes in the following cycle, and a one-cycle output strobe marks that cycle. If the strobe arrives while no symbol is buffered, the block sends the "no change" symbol and raises an underrun flag. The flag stays high until the writer delivers another byte.

Back-pressure rule: a byte transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly while the holding register is occupied. The writer may hold `in_valid` high with stable data for as long as it likes. A byte presented while `in_ready` is low is not taken.

Top module: `dibit_phase_enc`

## Requirements
- R1: After a synchronous reset, `phase_idx` is 0, `phase_stb` is 0, `underrun` is 0 and `in_ready` is 1, with both buffer stages empty.
- R2: In the cycle after a byte is accepted into an empty holding register, `in_ready` is low. A byte offered while `in_ready` is low is dropped and never transmitted.
- R3: A second byte can be accepted while the first is still being sent. On the strobe that consumes the last symbol of the first byte, the next byte is loaded, so its four symbols follow with no idle symbol in between.
- R4: Within a byte, the symbols leave in the order bits [1:0], [3:2], [5:4], [7:6]. Within a symbol, the higher bit is the one that comes first in the serial stream.
- R5: Each symbol maps to a phase step in units of 90 degrees: symbol 00 gives +1, 01 gives 0, 11 gives +3 and 10 gives +2.
- R6: `phase_idx` encodes 0, 90, 180 and 270 degrees as 0, 1, 2 and 3. It is updated modulo 4, so it wraps from 3 back to 0.
- R7: A strobe that finds no buffered symbol leaves the phase unchanged and sets `underrun`. The flag is cleared when a byte is next accepted. If a byte is accepted in the same cycle as such a strobe, the flag is set.
- R8: `phase_stb` is high in exactly the cycle after each `sym_tick`. `phase_idx` changes only in such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte offered by writer |
| in_data | input | 8 | Byte to transmit |
| in_ready | output | 1 | Holding register free |
| sym_tick | input | 1 | One-cycle symbol-rate strobe |
| phase_idx | output | 2 | Absolute phase index in 90 degree units |
| phase_stb | output | 1 | Marks the cycle with a freshly updated phase |
| underrun | output | 1 | An idle symbol was sent for lack of data |

## Verification
The hardest situation to reach is the hand-off on the strobe that takes the final symbol of one byte while a second byte waits in the holding register. A slip of one symbol there would insert an idle step or repeat a symbol. The stimulus writes a byte, lets it move into the shift register, then immediately fills the holding register and offers a third byte while `in_ready` is low. It then strobes eight times and checks every phase step against a model built from the step table. A ninth strobe confirms that the dropped byte never appears and that the underrun flag rises.

// File: rtl/dpe_pkg.sv
package dpe_pkg;
  localparam int SYM_W = 2;
  typedef logic [SYM_W-1:0] sym_t;

  // Step in quarter turns for each symbol value
  function automatic sym_t sym_to_step(input sym_t s);
    sym_t r;
    case (s)
      2'b00:   r = 2'd1;
      2'b01:   r = 2'd0;
      2'b11:   r = 2'd3;
      default: r = 2'd2;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dpe_hold_buf.sv
module dpe_hold_buf #(
  parameter int BYTE_W = 8,
  parameter int SYM_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic              sym_tick,
  output logic [SYM_W-1:0]  cur_sym,
  output logic              sym_live,
  output logic              underrun
);
  localparam int SYMS  = BYTE_W / SYM_W;
  localparam int CNT_W = $clog2(SYMS + 1);

  logic              hold_full_q;
  logic [BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              und_q;
  logic              accept, reload, shift_empty, last_sym;

  assign in_ready    = ~hold_full_q;
  assign accept      = in_valid & ~hold_full_q;
  assign shift_empty = (cnt_q == '0);
  assign last_sym    = (cnt_q == CNT_W'(1));
  assign reload      = hold_full_q & (shift_empty | (sym_tick & last_sym));
  assign cur_sym     = shift_q[SYM_W-1:0];
  assign sym_live    = ~shift_empty;
  assign underrun    = und_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full_q <= 1'b0;
      hold_q      <= '0;
      shift_q     <= '0;
      cnt_q       <= '0;
      und_q       <= 1'b0;
    end else begin
      if (accept) begin
        hold_q      <= in_data;
        hold_full_q <= 1'b1;
      end else if (reload) begin
        hold_full_q <= 1'b0;
      end

      if (reload) begin
        shift_q <= hold_q;
        cnt_q   <= CNT_W'(SYMS);
      end else if (sym_tick && !shift_empty) begin
        shift_q <= shift_q >> SYM_W;
        cnt_q   <= cnt_q - CNT_W'(1);
      end

      if (sym_tick && shift_empty) und_q <= 1'b1;
      else if (accept)             und_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dpe_step_map.sv
module dpe_step_map
  import dpe_pkg::*;
#(
  parameter sym_t IDLE_SYM = 2'b01
) (
  input  sym_t sym_in,
  input  logic live,
  output sym_t step
);
  sym_t eff;
  assign eff  = live ? sym_in : IDLE_SYM;
  assign step = sym_to_step(eff);
endmodule

// File: rtl/dpe_phase_acc.sv
module dpe_phase_acc #(
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [PH_W-1:0] step,
  output logic [PH_W-1:0] phase,
  output logic            stb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      stb   <= 1'b0;
    end else begin
      stb <= tick;
      if (tick) phase <= phase + step;
    end
  end
endmodule

// File: rtl/dibit_phase_enc.sv
module dibit_phase_enc
  import dpe_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic              sym_tick,
  output logic [SYM_W-1:0]  phase_idx,
  output logic              phase_stb,
  output logic              underrun
);
  sym_t cur_sym, step;
  logic sym_live;

  dpe_hold_buf #(.BYTE_W(BYTE_W), .SYM_W(SYM_W)) u_buf (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .sym_tick(sym_tick), .cur_sym(cur_sym),
    .sym_live(sym_live), .underrun(underrun)
  );

  dpe_step_map #(.IDLE_SYM(2'b01)) u_map (
    .sym_in(cur_sym), .live(sym_live), .step(step)
  );

  dpe_phase_acc #(.PH_W(SYM_W)) u_acc (
    .clk(clk), .rst(rst), .tick(sym_tick), .step(step),
    .phase(phase_idx), .stb(phase_stb)
  );
endmodule

// File: rtl/dpe_checker.sv
module dpe_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       sym_tick,
  input logic [1:0] phase_idx,
  input logic       phase_stb,
  input logic       underrun
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (phase_idx == 2'd0 && !phase_stb && !underrun && in_ready));

  p_full_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  p_idle_keeps_phase_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> (phase_idx == $past(phase_idx)));

  p_stb_after_tick_r8: assert property (@(posedge clk) disable iff (rst)
    sym_tick |=> phase_stb);

  p_no_stb_without_tick_r8: assert property (@(posedge clk) disable iff (rst)
    !sym_tick |=> (!phase_stb && $stable(phase_idx)));
endmodule

bind dibit_phase_enc dpe_checker u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .sym_tick(sym_tick), .phase_idx(phase_idx), .phase_stb(phase_stb),
  .underrun(underrun)
);

// File: tb/dibit_phase_enc_tb.sv
module dibit_phase_enc_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       sym_tick = 1'b0;
  logic       in_ready;
  logic [1:0] phase_idx;
  logic       phase_stb;
  logic       underrun;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] exp_ph = 2'd0;

  always #2.5 clk = ~clk;

  dibit_phase_enc u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .sym_tick(sym_tick), .phase_idx(phase_idx),
    .phase_stb(phase_stb), .underrun(underrun)
  );

  function automatic logic [1:0] step_of(input logic [1:0] s);
    if (s == 2'b00) return 2'd1;
    if (s == 2'b01) return 2'd0;
    if (s == 2'b10) return 2'd2;
    return 2'd3;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic tick_expect(input logic [1:0] sym, input logic live, input string req);
    @(negedge clk);
    sym_tick = 1'b1;
    @(negedge clk);
    sym_tick = 1'b0;
    exp_ph = exp_ph + (live ? step_of(sym) : 2'd0);
    check({req, " phase"}, phase_idx, exp_ph);
    check("R8 stb", phase_stb, 1);
  endtask

  task automatic send_byte_ticks(input logic [7:0] b, input string req);
    for (int k = 0; k < 4; k++) tick_expect(b[2*k +: 2], 1'b1, req);
  endtask

  task automatic t_reset;
    check("R1 phase", phase_idx, 0);
    check("R1 stb", phase_stb, 0);
    check("R1 underrun", underrun, 0);
    check("R1 ready", in_ready, 1);
  endtask

  task automatic t_order_and_map;
    // 0xE4: symbols out 00,01,10,11
    write_byte(8'hE4);
    @(negedge clk);
    send_byte_ticks(8'hE4, "R4 R5");
    @(negedge clk);
    check("R8 stb idle", phase_stb, 0);
    check("R8 phase hold", phase_idx, exp_ph);
  endtask

  task automatic t_wrap;
    // four +1 steps walk through 3 -> 0
    write_byte(8'h00);
    @(negedge clk);
    send_byte_ticks(8'h00, "R6");
    check("R7 no underrun", underrun, 0);
  endtask

  task automatic t_back_to_back;
    write_byte(8'h1B);
    @(negedge clk);
    check("R2 ready after move", in_ready, 1);
    write_byte(8'h4E);
    check("R2 ready low when full", in_ready, 0);
    write_byte(8'hAA); // must be dropped
    send_byte_ticks(8'h1B, "R3 first");
    send_byte_ticks(8'h4E, "R3 second");
    check("R3 no underrun", underrun, 0);
    tick_expect(2'b00, 1'b0, "R2 dropped byte absent");
    check("R7 underrun set", underrun, 1);
  endtask

  task automatic t_underrun;
    tick_expect(2'b00, 1'b0, "R7 idle");
    check("R7 underrun held", underrun, 1);
    write_byte(8'h27);
    check("R7 underrun cleared", underrun, 0);
    @(negedge clk);
    send_byte_ticks(8'h27, "R5 after underrun");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order_and_map();
    t_wrap();
    t_back_to_back();
    t_underrun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule